// File: doc/BRIEF.md
# Banked ROM Mapper with On-Board Nibble RAM

This block sits between a CPU bus (16-bit address, 8-bit data) and a cartridge ROM array. It turns every read in the lower half of the address space into an address into that ROM. Addresses 0x0000-0x3FFF always map to the first 16 KiB of ROM. Addresses 0x4000-0x7FFF map into a 16 KiB page picked by a 4-bit bank register. It also holds its own small scratch memory of 512 entries, each 4 bits wide. The CPU reaches this memory through the 0xA000-0xBFFF window, where the 512 entries repeat every 512 bytes.

Control writes land in 0x0000-0x3FFF. Address bit 8 chooses the target. With bit 8 clear, the write arms or disarms the scratch memory. With bit 8 set, it loads the bank register. While the memory is disarmed, the window reads all ones and ignores writes. The number of ROM pages is a parameter (a power of two from 2 to 16), and the page number is masked to it. The reset input is asynchronous and active low; its release is synchronised inside the block.

Top module: `cart_nibble_mapper`

## Requirements
- R1: After reset the scratch memory is disarmed (reads at 0xA000-0xBFFF give 0xFF) and the bank register holds 1, so a read at 0x4000 gives ROM address 0x04000.
- R2: A read in 0x0000-0x3FFF raises rom_sel and drives rom_addr equal to the CPU address, whatever the bank register holds.
- R3: A read in 0x4000-0x7FFF raises rom_sel and drives rom_addr = bank × 0x4000 + (address − 0x4000), with the bank masked to ROM_BANKS−1.
- R4: A write in 0x0000-0x3FFF with address bit 8 set loads data bits 3:0 into the bank register, ignoring data bits 7:4. A value of 0 is stored as 1.
- R5: A write in 0x0000-0x3FFF with address bit 8 clear arms the scratch memory when data bits 3:0 equal 0xA (bits 7:4 ignored) and disarms it for any other value.
- R6: While armed, a read in 0xA000-0xBFFF returns 0xF in bits 7:4 and the stored nibble in bits 3:0.
- R7: A write to the window stores only data bits 3:0.
- R8: The scratch entry is chosen by address bits 8:0, so the 512 entries repeat across the whole window.
- R9: While disarmed, window reads return 0xFF and window writes leave the stored contents unchanged.
- R10: Writes in 0x4000-0x7FFF change neither the bank register, the arm state nor the scratch contents.
- R11: Outside 0x0000-0x7FFF rom_sel is low and rom_addr is 0. Outside 0xA000-0xBFFF ram_sel is low and rd_data is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | Write strobe, taken at the rising clock edge |
| bus_wdata | input | 8 | CPU write data |
| rom_sel | output | 1 | Address falls in the ROM range |
| rom_addr | output | 14+log2(ROM_BANKS) | Address into the ROM array |
| ram_sel | output | 1 | Address falls in the scratch-memory window |
| rd_data | output | 8 | Byte the mapper itself serves for the window |

## Verification
The assertions check a set of properties on every cycle. The bank register never holds zero. Neither control register moves without its own write strobe. A disarmed window always reads 0xFF, and a window read always carries ones in its upper nibble. The lower ROM range passes the address straight through, and the two select outputs never rise together. Some behaviour only the bench scenarios can show. These are the mirroring of entries across the window, that only the low nibble is stored, and that a disarmed write leaves the old value in place. Each needs a write followed by a later read at another address, or after the arm state has changed.

// File: rtl/cnm_pkg.sv
package cnm_pkg;
  localparam int NIB_W      = 4;
  localparam int RAM_DEPTH  = 512;
  localparam int RAM_AW     = $clog2(RAM_DEPTH);
  localparam int BANK_REG_W = 4;
  localparam int PAGE_OFS_W = 14;
  localparam logic [NIB_W-1:0] ARM_KEY = 4'hA;
  localparam logic [BANK_REG_W-1:0] BANK_RST = 4'd1;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_ROM_LO,
    WIN_ROM_HI,
    WIN_NRAM
  } win_e;
endpackage

// File: rtl/cnm_rst_sync.sv
module cnm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cnm_decode.sv
module cnm_decode
  import cnm_pkg::*;
(
  input  logic [2:0] addr_top,
  input  logic       addr_sel,
  input  logic       wr,
  output win_e       win,
  output logic       arm_wr,
  output logic       bank_wr,
  output logic       nram_wr
);
  always_comb begin
    unique case (addr_top)
      3'b000, 3'b001: win = WIN_ROM_LO;
      3'b010, 3'b011: win = WIN_ROM_HI;
      3'b101:         win = WIN_NRAM;
      default:        win = WIN_NONE;
    endcase
  end

  always_comb begin
    arm_wr  = wr && (win == WIN_ROM_LO) && !addr_sel;
    bank_wr = wr && (win == WIN_ROM_LO) &&  addr_sel;
    nram_wr = wr && (win == WIN_NRAM);
  end
endmodule

// File: rtl/cnm_ctrl.sv
module cnm_ctrl
  import cnm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  arm_wr,
  input  logic                  bank_wr,
  input  logic [NIB_W-1:0]      wnib,
  output logic                  armed,
  output logic [BANK_REG_W-1:0] bank
);
  logic                  armed_q, armed_nxt;
  logic [BANK_REG_W-1:0] bank_q, bank_nxt;

  always_comb begin
    armed_nxt = (wnib == ARM_KEY);
    bank_nxt  = (wnib == '0) ? BANK_RST : wnib;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      bank_q  <= BANK_RST;
    end else begin
      if (arm_wr)  armed_q <= armed_nxt;
      if (bank_wr) bank_q  <= bank_nxt;
    end
  end

  assign armed = armed_q;
  assign bank  = bank_q;

  // R10
  arm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arm_wr |=> $stable(armed_q));
  // R10
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_wr |=> $stable(bank_q));
  // R5
  arm_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_wr |=> (armed_q == ($past(wnib) == ARM_KEY)));
  // R4
  bank_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_q != '0);
endmodule

// File: rtl/cnm_nib_ram.sv
module cnm_nib_ram #(
  parameter int DEPTH = 512,
  parameter int W     = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/cart_nibble_mapper.sv
module cart_nibble_mapper
  import cnm_pkg::*;
#(
  parameter int ROM_BANKS = 16,
  localparam int BANK_AW  = $clog2(ROM_BANKS),
  localparam int ROM_AW   = PAGE_OFS_W + BANK_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_sel,
  output logic [7:0]        rd_data
);
  logic                  rst_sync_n;
  win_e                  win;
  logic                  arm_wr, bank_wr, nram_wr, nram_we, armed;
  logic [BANK_REG_W-1:0] bank;
  logic [NIB_W-1:0]      nib_rd;

  cnm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cnm_decode u_dec (
    .addr_top (bus_addr[15:13]),
    .addr_sel (bus_addr[8]),
    .wr       (bus_wr),
    .win      (win),
    .arm_wr   (arm_wr),
    .bank_wr  (bank_wr),
    .nram_wr  (nram_wr)
  );

  cnm_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .arm_wr  (arm_wr),
    .bank_wr (bank_wr),
    .wnib    (bus_wdata[NIB_W-1:0]),
    .armed   (armed),
    .bank    (bank)
  );

  assign nram_we = nram_wr && armed;

  cnm_nib_ram #(.DEPTH(RAM_DEPTH), .W(NIB_W)) u_ram (
    .clk   (clk),
    .we    (nram_we),
    .waddr (bus_addr[RAM_AW-1:0]),
    .wdata (bus_wdata[NIB_W-1:0]),
    .raddr (bus_addr[RAM_AW-1:0]),
    .rdata (nib_rd)
  );

  always_comb begin
    rom_sel = (win == WIN_ROM_LO) || (win == WIN_ROM_HI);
    ram_sel = (win == WIN_NRAM);
    unique case (win)
      WIN_ROM_LO: rom_addr = {{BANK_AW{1'b0}}, bus_addr[PAGE_OFS_W-1:0]};
      WIN_ROM_HI: rom_addr = {bank[BANK_AW-1:0], bus_addr[PAGE_OFS_W-1:0]};
      default:    rom_addr = '0;
    endcase
    if (ram_sel && armed) rd_data = {4'hF, nib_rd};
    else                  rd_data = 8'hFF;
  end

  // R9
  off_read_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ram_sel && !armed) |-> (rd_data == 8'hFF));
  // R6
  hi_ones_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ram_sel |-> (rd_data[7:4] == 4'hF));
  // R2
  lo_pass_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rom_sel && !bus_addr[14]) |-> (rom_addr == ROM_AW'(bus_addr[13:0])));
  // R11
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0({rom_sel, ram_sel}));
  // R4
  bank_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bank_wr && bus_wdata[3:0] != 4'h0) |=> ({4'h0, bank} == ($past(bus_wdata) & 8'h0F)));
endmodule

// File: tb/cart_nibble_mapper_tb.sv
module cart_nibble_mapper_tb;
  localparam int RA_W = 18;

  logic            clk;
  logic            rst_n;
  logic [15:0]     bus_addr;
  logic            bus_wr;
  logic [7:0]      bus_wdata;
  logic            rom_sel;
  logic [RA_W-1:0] rom_addr;
  logic            ram_sel;
  logic [7:0]      rd_data;

  cart_nibble_mapper u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .rom_sel   (rom_sel),
    .rom_addr  (rom_addr),
    .ram_sel   (ram_sel),
    .rd_data   (rd_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    string           req;
    logic [15:0]     addr;
    logic            rs;
    logic [RA_W-1:0] ra;
    logic            ms;
    logic [7:0]      rd;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  // reference model built from the requirements
  logic       m_armed;
  logic [3:0] m_bank;
  logic [3:0] m_mem [512];

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    if (a[15:14] == 2'b00) begin
      if (a[8]) m_bank = (d[3:0] == 4'h0) ? 4'd1 : d[3:0];
      else      m_armed = (d[3:0] == 4'hA);
    end else if (a[15:13] == 3'b101 && m_armed) begin
      m_mem[a[8:0]] = d[3:0];
    end
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input string req, input logic [15:0] a);
    exp_t e;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    e.req = req; e.addr = a;
    e.rs = (a[15] == 1'b0);
    e.ms = (a[15:13] == 3'b101);
    if (a[15:14] == 2'b00)      e.ra = {4'h0, a[13:0]};
    else if (a[15:14] == 2'b01) e.ra = {m_bank, a[13:0]};
    else                        e.ra = '0;
    e.rd = (e.ms && m_armed) ? {4'hF, m_mem[a[8:0]]} : 8'hFF;
    q.push_back(e);
  endtask

  // monitor: pops expected items and compares them with the outputs
  initial begin
    forever begin
      @(negedge clk);
      #5;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (rom_sel !== e.rs || rom_addr !== e.ra || ram_sel !== e.ms || rd_data !== e.rd) begin
          n_bad++;
          $display("FAIL %s addr=%h: got rom_sel=%b rom_addr=%h ram_sel=%b rd=%h, expected %b %h %b %h",
                   e.req, e.addr, rom_sel, rom_addr, ram_sel, rd_data, e.rs, e.ra, e.ms, e.rd);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    m_armed = 1'b0; m_bank = 4'd1;
    for (int i = 0; i < 512; i++) m_mem[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R2 straight ROM mapping
    do_read("R2", 16'h0123);
    do_read("R1", 16'h4000);
    do_read("R1", 16'hA000);

    // R5 arm, R7 low nibble only, R6 upper ones
    do_write(16'h0000, 8'h0A);
    do_write(16'hA005, 8'h37);
    do_read("R6_R7", 16'hA005);
    // R8 mirroring
    do_read("R8", 16'hA205);
    do_read("R8", 16'hBE05);
    do_write(16'hA1FF, 8'hFC);
    do_read("R8", 16'hBFFF);

    // R4 bank loads, upper data bits ignored; R3 banked mapping
    do_write(16'h2100, 8'h35);
    do_read("R3", 16'h7ABC);
    do_read("R2", 16'h3FFF);
    do_write(16'h0100, 8'h00);
    do_read("R4", 16'h4001);
    do_write(16'h3FFF, 8'h0F);
    do_read("R3", 16'h7FFF);

    // R10 writes in the banked range change nothing
    do_write(16'h4100, 8'h03);
    do_write(16'h6000, 8'h00);
    do_write(16'h7005, 8'h0A);
    do_read("R10", 16'h7FFF);
    do_read("R10", 16'hA005);

    // R5 disarm, R9 disarmed reads and ignored writes
    do_write(16'h1000, 8'h1B);
    do_read("R9", 16'hA005);
    do_write(16'hA005, 8'h02);
    do_write(16'h00FF, 8'hFA);
    do_read("R5_R9", 16'hA005);

    // R11 outside both windows
    do_read("R11", 16'h8000);
    do_read("R11", 16'h9FFF);
    do_read("R11", 16'hC000);
    do_read("R11", 16'hFFFF);

    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule